// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block does the add and subtract work for a 16-bit processor and keeps that processor's flag word. Each operation takes two operands, a carry-in and two selects. One select chooses add or subtract. The other chooses byte or word width. In byte width only the low eight bits of each operand take part, and the upper byte of the result is zero.

When the update enable is high, the result and six status flags load on the clock edge. The status flags are carry/borrow, parity, half-carry, zero, sign and signed overflow. Three control flags sit beside them: trap, interrupt enable and string direction. Arithmetic never touches the control flags. They change only through a write command that names one of them and supplies its new value.

A sequencer drives the operands and the command pins each cycle. It reads the flag word back for conditional decisions.

Top module: `arith_flag_unit`

## Requirements
- R1: With `opSub`=0 and update enabled, `result` becomes `opA + opB + carryIn` modulo the width. In byte width (`wordMode`=0), only bits 7:0 of the operands are used, and bits 15:8 of `result` are 0.
- R2: With `opSub`=1 and update enabled, `result` becomes `opA - opB - carryIn` modulo the selected width, under the same byte-width rule.
- R3: `flags[0]` (carry) is 1 when an add produces an unsigned value above the width's maximum, for example byte 255 + 1. It is also 1 when a subtract needs a borrow, meaning the minuend is below subtrahend plus carry-in. Otherwise it is 0.
- R4: `flags[1]` (parity) is 1 when bits 7:0 of the new result hold an even number of ones, and 0 when odd. This holds in word width too.
- R5: `flags[2]` (half-carry) is 1 when the low four bits produce a carry out on add, or need a borrow on subtract. Otherwise it is 0.
- R6: `flags[3]` (zero) is 1 exactly when the new result, at the selected width, is zero.
- R7: `flags[4]` (sign) equals bit 7 of the new result in byte width and bit 15 in word width.
- R8: `flags[5]` (overflow) is 1 when the true two's-complement result falls outside the selected width's signed range, for example byte 100 + 50. Otherwise it is 0.
- R9: With `updateEn`=0, `result` and `flags[5:0]` keep their values whatever the operands and selects are.
- R10: With `ctlWrEn`=1, `ctlVal` is written into one control flag chosen by `ctlSel`. Code 0 selects direction in `flags[8]` (0 = incrementing string steps). Code 1 selects interrupt enable in `flags[7]`. Code 2 selects trap in `flags[6]`. Code 3 changes no flag.
- R11: `flags[8:6]` change only on a write command. Arithmetic updates, in the same cycle or any other, leave them unchanged.
- R12: While `rstN` is low, `result` and all of `flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand (minuend on subtract) |
| opB | input | 16 | Second operand (subtrahend on subtract) |
| carryIn | input | 1 | Carry-in on add, borrow-in on subtract |
| opSub | input | 1 | 0 = add, 1 = subtract |
| wordMode | input | 1 | 0 = byte width, 1 = word width |
| updateEn | input | 1 | Load result and status flags this cycle |
| ctlWrEn | input | 1 | Write a control flag this cycle |
| ctlSel | input | 2 | Control flag select: 0 direction, 1 interrupt enable, 2 trap, 3 none |
| ctlVal | input | 1 | Value written to the selected control flag |
| result | output | 16 | Registered arithmetic result |
| flags | output | 9 | Flag word: 0 carry, 1 parity, 2 half-carry, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable, 8 direction |

## Verification
The bench targets these corner cases:

- Byte 255 + 1. Carry, half-carry, zero and parity must all set. A design that took the carry from bit 16 instead of bit 8 would leave carry clear.
- Word results whose low byte is 0x00. Parity must still set. A design that counted all sixteen bits would give the wrong parity on such values as 0x0100.
- Signed overflow in both directions, including byte 100 + 50 and subtracts across the sign boundary. A design that reused the add overflow rule for subtract would report the wrong value.
- Subtract with borrow-in. Carry and half-carry must report borrows.
- Control-flag writes that arrive in the same cycle as an update, and writes with the unused select code. These expose a design that lets arithmetic, or a stray code, disturb the trap, interrupt-enable or direction flags.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int FLAG_N = 9;
  localparam int CTL_N  = 3;
  // flag word positions
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;
  localparam int FL_TF = 6;
  localparam int FL_IF = 7;
  localparam int FL_DF = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadArith;
    logic             subSel;
    logic             byteSel;
    logic             carryIn;
    logic [CTL_N-1:0] ctlSet;   // index g targets flag FL_DF - g
    logic [CTL_N-1:0] ctlClr;
  } afuStrobe_t;
endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic       opSub,
  input  logic       wordMode,
  input  logic       carryIn,
  input  logic       updateEn,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlSel,
  input  logic       ctlVal,
  output afuStrobe_t strb
);
  logic [CTL_N-1:0] setVec;
  logic [CTL_N-1:0] clrVec;

  for (genvar g = 0; g < CTL_N; g++) begin : g_ctlDecode
    assign setVec[g] = ctlWrEn && (ctlSel == 2'(g)) &&  ctlVal;
    assign clrVec[g] = ctlWrEn && (ctlSel == 2'(g)) && !ctlVal;
  end

  always_comb begin
    strb.loadArith = updateEn;
    strb.subSel    = opSub;
    strb.byteSel   = !wordMode;
    strb.carryIn   = carryIn;
    strb.ctlSet    = setVec;
    strb.ctlClr    = clrVec;
  end
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  afuStrobe_t        strb,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flags
);
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int HI_W   = DATA_W - BYTE_W;

  logic [DATA_W-1:0] aIn, bIn, resNext;
  logic [DATA_W:0]   sumExt;
  logic [NIB_W:0]    nibExt;
  logic              cfNext, afNext, ofNext, pfNext, zfNext, sfNext;
  logic              msbA, msbB, msbR;

  always_comb begin
    aIn = strb.byteSel ? {{HI_W{1'b0}}, opA[BYTE_W-1:0]} : opA;
    bIn = strb.byteSel ? {{HI_W{1'b0}}, opB[BYTE_W-1:0]} : opB;
    if (strb.subSel) begin
      sumExt = {1'b0, aIn} - {1'b0, bIn} - {{DATA_W{1'b0}}, strb.carryIn};
      nibExt = {1'b0, aIn[NIB_W-1:0]} - {1'b0, bIn[NIB_W-1:0]}
             - {{NIB_W{1'b0}}, strb.carryIn};
    end else begin
      sumExt = {1'b0, aIn} + {1'b0, bIn} + {{DATA_W{1'b0}}, strb.carryIn};
      nibExt = {1'b0, aIn[NIB_W-1:0]} + {1'b0, bIn[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, strb.carryIn};
    end
    resNext = strb.byteSel ? {{HI_W{1'b0}}, sumExt[BYTE_W-1:0]} : sumExt[DATA_W-1:0];
    cfNext  = strb.byteSel ? sumExt[BYTE_W] : sumExt[DATA_W];
    afNext  = nibExt[NIB_W];
    msbA    = strb.byteSel ? aIn[BYTE_W-1] : aIn[DATA_W-1];
    msbB    = strb.byteSel ? bIn[BYTE_W-1] : bIn[DATA_W-1];
    msbR    = strb.byteSel ? resNext[BYTE_W-1] : resNext[DATA_W-1];
    ofNext  = strb.subSel ? ((msbA != msbB) && (msbR != msbA))
                          : ((msbA == msbB) && (msbR != msbA));
    pfNext  = ~^resNext[BYTE_W-1:0];
    zfNext  = (resNext == '0);
    sfNext  = msbR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else begin
      if (strb.loadArith) begin
        result       <= resNext;
        flags[FL_CF] <= cfNext;
        flags[FL_PF] <= pfNext;
        flags[FL_AF] <= afNext;
        flags[FL_ZF] <= zfNext;
        flags[FL_SF] <= sfNext;
        flags[FL_OF] <= ofNext;
      end
      for (int g = 0; g < CTL_N; g++) begin
        if (strb.ctlSet[g])      flags[FL_DF-g] <= 1'b1;
        else if (strb.ctlClr[g]) flags[FL_DF-g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              opSub,
  input  logic              wordMode,
  input  logic              updateEn,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlSel,
  input  logic              ctlVal,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flags
);
  afuStrobe_t strb;

  afu_ctrl ctrl_i (
    .opSub(opSub), .wordMode(wordMode), .carryIn(carryIn), .updateEn(updateEn),
    .ctlWrEn(ctlWrEn), .ctlSel(ctlSel), .ctlVal(ctlVal), .strb(strb)
  );

  afu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .strb(strb),
    .result(result), .flags(flags)
  );
endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordMode,
  input logic              updateEn,
  input logic              ctlWrEn,
  input logic [1:0]        ctlSel,
  input logic [DATA_W-1:0] result,
  input logic [8:0]        flags
);
  assert_hold_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |=> ($stable(result) && $stable(flags[5:0])));

  assert_ctl_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> $stable(flags[8:6]));

  assert_unused_sel_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlSel == 2'd3) |=> $stable(flags[8:6]));

  assert_zero_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    updateEn |=> (flags[3] == (result == '0)));

  assert_parity_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    updateEn |=> (flags[1] == ~^result[7:0]));

  assert_sign_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && !wordMode) |=> (flags[4] == result[7]));

  assert_sign_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && wordMode) |=> (flags[4] == result[DATA_W-1]));

  assert_byte_upper_R1: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && !wordMode) |=> (result[DATA_W-1:8] == '0));
endmodule

bind arith_flag_unit arith_flag_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wordMode(wordMode), .updateEn(updateEn),
  .ctlWrEn(ctlWrEn), .ctlSel(ctlSel), .result(result), .flags(flags)
);

// File: tb/arith_flag_unit_tb_top.sv
`timescale 1ns/1ps
module arith_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0, opSub = 1'b0, wordMode = 1'b0, updateEn = 1'b0;
  logic        ctlWrEn = 1'b0, ctlVal = 1'b0;
  logic [1:0]  ctlSel = '0;
  logic [15:0] result;
  logic [8:0]  flags;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  int expRes = 0;
  int expFl[9];

  always #2 clk = ~clk;

  arith_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .opSub(opSub), .wordMode(wordMode), .updateEn(updateEn),
    .ctlWrEn(ctlWrEn), .ctlSel(ctlSel), .ctlVal(ctlVal),
    .result(result), .flags(flags)
  );

  task automatic check(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int toSigned(int v, int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  // behavioural reference for one clock edge, from the driven inputs
  task automatic modelEdge();
    int w, mask, a, b, c, full, nib, sres, ones, r;
    if (updateEn) begin
      w = wordMode ? 16 : 8;
      mask = (1 << w) - 1;
      a = int'(opA) & mask; b = int'(opB) & mask; c = int'(carryIn);
      if (opSub) begin
        full = a - b - c;
        nib  = (a & 15) - (b & 15) - c;
        sres = toSigned(a, w) - toSigned(b, w) - c;
        expFl[0] = (full < 0);
        expFl[2] = (nib < 0);
      end else begin
        full = a + b + c;
        nib  = (a & 15) + (b & 15) + c;
        sres = toSigned(a, w) + toSigned(b, w) + c;
        expFl[0] = (full > mask);
        expFl[2] = (nib > 15);
      end
      r = full & mask;
      expRes = r;
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      expFl[1] = (ones % 2 == 0);
      expFl[3] = (r == 0);
      expFl[4] = (r >> (w-1)) & 1;
      expFl[5] = (sres < -(1 << (w-1))) || (sres > (1 << (w-1)) - 1);
    end
    if (ctlWrEn) begin
      case (ctlSel)
        2'd0: expFl[8] = ctlVal;
        2'd1: expFl[7] = ctlVal;
        2'd2: expFl[6] = ctlVal;
        default: ;
      endcase
    end
  endtask

  task automatic compareAll(bit upd, bit sub, bit cw);
    string rr;
    rr = !upd ? "R9" : (sub ? "R2" : "R1");
    check(rr, "result", int'(result), expRes);
    check(upd ? "R3" : "R9", "carry", int'(flags[0]), expFl[0]);
    check(upd ? "R4" : "R9", "parity", int'(flags[1]), expFl[1]);
    check(upd ? "R5" : "R9", "halfcarry", int'(flags[2]), expFl[2]);
    check(upd ? "R6" : "R9", "zero", int'(flags[3]), expFl[3]);
    check(upd ? "R7" : "R9", "sign", int'(flags[4]), expFl[4]);
    check(upd ? "R8" : "R9", "overflow", int'(flags[5]), expFl[5]);
    check(cw ? "R10" : "R11", "trap", int'(flags[6]), expFl[6]);
    check(cw ? "R10" : "R11", "intEnable", int'(flags[7]), expFl[7]);
    check(cw ? "R10" : "R11", "direction", int'(flags[8]), expFl[8]);
  endtask

  // drive at negedge, model the posedge, compare at next negedge
  task automatic cycle(logic [15:0] a, logic [15:0] b, bit cin, bit sub, bit word,
                       bit upd, bit cw, logic [1:0] sel, bit val);
    bit u, s, c;
    opA = a; opB = b; carryIn = cin; opSub = sub; wordMode = word;
    updateEn = upd; ctlWrEn = cw; ctlSel = sel; ctlVal = val;
    u = upd; s = sub; c = cw;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(u, s, c);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) expFl[i] = 0;
    repeat (3) @(negedge clk);
    check("R12", "reset result", int'(result), 0);
    check("R12", "reset flags", int'(flags), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4 R5 R6: byte 255 + 1
    cycle(16'h00FF, 16'h0001, 0, 0, 0, 1, 0, 0, 0);
    // R8: byte 100 + 50, upper operand bytes ignored (R1)
    cycle(16'hAB64, 16'hCD32, 0, 0, 0, 1, 0, 0, 0);
    // word signed overflow
    cycle(16'h7FFF, 16'h0001, 0, 0, 1, 1, 0, 0, 0);
    // R4: word result 0x0100, low byte zero ones
    cycle(16'h00FF, 16'h0001, 0, 0, 1, 1, 0, 0, 0);
    // R2 borrow: 0 - 1 word
    cycle(16'h0000, 16'h0001, 0, 1, 1, 1, 0, 0, 0);
    // subtract with borrow-in, byte, signed overflow -128 - 1
    cycle(16'h0080, 16'h0000, 1, 1, 0, 1, 0, 0, 0);
    // R9: hold with update low
    cycle(16'h1234, 16'h4321, 1, 0, 1, 0, 0, 0, 0);
    // R10: control writes, with arithmetic in same cycle (R11)
    cycle(16'h0010, 16'h0020, 0, 0, 1, 1, 1, 2'd0, 1);
    cycle(16'h0005, 16'h0005, 0, 1, 0, 1, 1, 2'd1, 1);
    cycle(16'h0000, 16'h0000, 0, 0, 0, 0, 1, 2'd2, 1);
    cycle(16'h0000, 16'h0000, 0, 0, 0, 0, 1, 2'd3, 0);
    cycle(16'h0000, 16'h0000, 0, 0, 0, 0, 1, 2'd1, 0);
    cycle(16'hFFFF, 16'hFFFF, 1, 0, 1, 1, 0, 0, 0);
    // mixed stimulus
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      cycle(r1[15:0], r1[31:16], r2[0], r2[1], r2[2], r2[3] | r2[4],
            r2[5] & r2[6], r2[8:7], r2[9]);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule